// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. The host places a character in a one-entry holding buffer. At the next bit boundary the character moves into a frame shifter, and the buffer is then free for the following character. Because of this, characters can be sent back to back with no idle gap between frames.

Each frame is a low start bit, followed by 7 or 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The bit timing comes from an oversampling tick supplied by an external baud divider. One bit lasts a fixed number of ticks.

Two status flags tell the host the state of the block. One shows that the holding buffer is empty. The other shows that the shifter has reached its last stop bit with nothing waiting behind it. A single interrupt output pulses when the flag the host has selected goes high.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1, shift_done is 1 and tx_irq is 0.
- R2: A frame is one start bit at 0, then the data bits least significant bit first, then the parity bit when cfg_par_en is 1, then the stop bits at 1. cfg_len8=1 sends 8 data bits and cfg_len8=0 sends 7. cfg_stop2=1 sends two stop bits and cfg_stop2=0 sends one. The line rests at 1 between frames.
- R3: With cfg_par_odd=0 the parity bit makes the count of ones over the data bits and the parity bit even. With cfg_par_odd=1 it makes that count odd. With 7-bit characters, wr_data bit 7 is left out of the frame and out of the parity.
- R4: buf_empty is 0 in the cycle after a wr_en cycle. It returns to 1 in the same cycle in which the start bit of that character appears on txd.
- R5: A character moves into the shifter only at a bit boundary. txd changes only in the cycle after an os_tick. From idle, the start bit appears at most OVS ticks after the write.
- R6: shift_done goes to 0 when a start bit appears. It returns to 1 at the start of the last stop bit, which is the second stop bit when cfg_stop2=1, but only if the holding buffer is empty at that moment.
- R7: A character written while another frame is being sent is kept in the buffer. Its start bit follows the previous last stop bit directly, and shift_done stays 0 across the join.
- R8: tx_irq is high for exactly one cycle, the cycle after the selected flag rises. cfg_irq_done=0 selects buf_empty and cfg_irq_done=1 selects shift_done.
- R9: Every bit of a frame lasts exactly OVS os_tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable from the baud divider |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Adds a parity bit to the frame |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_irq_done | input | 1 | Interrupt source: 1 shift_done, 0 buf_empty |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is free |
| shift_done | output | 1 | Shifter idle or on its final stop bit with nothing pending |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
buf_empty is checked one cycle after the write. The start bit, the rise of buf_empty and the fall of shift_done are all checked in the first cycle in which txd reads low. The interrupt is checked one cycle after that. Every frame bit is sampled half a bit after its boundary, which the bench finds by counting ticks from the start-bit edge, so every sample falls OVS/2 ticks away from any change. The load delay is checked as a cycle window bounded by one bit period at the current tick rate. Back-to-back frames are sampled across the join without resynchronising.

// File: rtl/utx_pkg.sv
package utx_pkg;
   typedef struct packed {
      logic len8;
      logic par_en;
      logic par_odd;
      logic stop2;
   } frame_cfg_t;
endpackage

// File: rtl/utx_baud_phase.sv
module utx_baud_phase #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic os_tick,
   output logic bit_edge
);
   generate
      if (OVS == 1) begin : g_direct
         assign bit_edge = os_tick;
      end else begin : g_count
         localparam int PH_W = $clog2(OVS);
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
         logic [PH_W-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (os_tick)
               phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
         end
         assign bit_edge = os_tick && (phase_q == PH_LAST);
      end
   endgenerate
endmodule

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          take,
   output logic [DW-1:0] data_q,
   output logic          full_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else if (wr_en) begin
         data_q <= wr_data;
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import utx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_edge,
   input  frame_cfg_t    cfg,
   input  logic          hold_full,
   input  logic [DW-1:0] hold_data,
   output logic          load,
   output logic          txd,
   output logic          shift_done
);
   localparam int FRAME_W = DW + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] frame_q, built;
   logic [CNT_W-1:0]   left_q, nbits, flen;
   logic [DW-1:0]      mask;
   logic               par;
   logic               done_q;

   always_comb begin
      nbits = cfg.len8 ? CNT_W'(DW) : CNT_W'(DW - 1);
      mask  = '1;
      if (!cfg.len8) mask[DW-1] = 1'b0;
      par   = (^(hold_data & mask)) ^ cfg.par_odd;
      flen  = CNT_W'(1) + nbits + CNT_W'(cfg.par_en) + (cfg.stop2 ? CNT_W'(2) : CNT_W'(1));
      built = '1;
      built[0] = 1'b0;
      for (int i = 0; i < DW; i++)
         if (i < int'(nbits)) built[i+1] = hold_data[i];
      if (cfg.par_en) built[int'(nbits)+1] = par;
   end

   assign load = bit_edge && hold_full && (left_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1;
         left_q  <= '0;
         done_q  <= 1'b1;
      end else if (load) begin
         frame_q <= built;
         left_q  <= flen;
         done_q  <= 1'b0;
      end else if (bit_edge && (left_q != '0)) begin
         frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
         left_q  <= left_q - 1'b1;
         if ((left_q == CNT_W'(2)) && !hold_full) done_q <= 1'b1;
      end
   end

   assign txd        = frame_q[0];
   assign shift_done = done_q;
endmodule

// File: rtl/utx_irq_gen.sv
module utx_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_done,
   input  logic buf_empty,
   input  logic shift_done,
   output logic irq
);
   logic empty_d, done_d, irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_d <= 1'b1;
         done_d  <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         empty_d <= buf_empty;
         done_d  <= shift_done;
         irq_q   <= sel_done ? (shift_done & ~done_d) : (buf_empty & ~empty_d);
      end
   end
   assign irq = irq_q;
endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
   import utx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              cfg_len8,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop2,
   input  logic              cfg_irq_done,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              buf_empty,
   output logic              shift_done,
   output logic              tx_irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ser_tx_dbuf: DATA_W must be at least 2");
      end
      if (OVS < 1) begin : g_bad_ovs
         $error("ser_tx_dbuf: OVS must be at least 1");
      end
   endgenerate

   frame_cfg_t        cfg;
   logic              bit_edge, load, hold_full;
   logic [DATA_W-1:0] hold_data;

   assign cfg = '{len8: cfg_len8, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

   utx_baud_phase #(.OVS(OVS)) u_phase (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .bit_edge(bit_edge)
   );

   utx_hold_buf #(.DW(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .take(load), .data_q(hold_data), .full_q(hold_full)
   );

   utx_shifter #(.DW(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .bit_edge(bit_edge), .cfg(cfg),
      .hold_full(hold_full), .hold_data(hold_data), .load(load),
      .txd(txd), .shift_done(shift_done)
   );

   utx_irq_gen u_irq (
      .clk(clk), .rst_n(rst_n), .sel_done(cfg_irq_done), .buf_empty(buf_empty),
      .shift_done(shift_done), .irq(tx_irq)
   );

   assign buf_empty = ~hold_full;
endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic os_tick,
   input logic wr_en,
   input logic cfg_irq_done,
   input logic txd,
   input logic buf_empty,
   input logic shift_done,
   input logic tx_irq
);
   // R4: a write occupies the buffer
   p_wr_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !buf_empty);
   // R4: the buffer frees only as a start bit is launched
   p_free_with_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> !txd);
   // R5: the line moves only after an oversampling tick
   p_txd_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(os_tick));
   // R6: while shift_done is high the line is at a stop or idle level
   p_done_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_done |-> txd);
   // R8: single-cycle pulse
   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);
   // R8: pulse follows a rise of the selected flag
   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> ($past(cfg_irq_done) ? ($past(shift_done) && !$past(shift_done, 2))
                                      : ($past(buf_empty) && !$past(buf_empty, 2))));
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en),
   .cfg_irq_done(cfg_irq_done), .txd(txd), .buf_empty(buf_empty),
   .shift_done(shift_done), .tx_irq(tx_irq)
);

// File: tb/sim_ser_tx_dbuf.sv
`timescale 1ns/1ps
module sim_ser_tx_dbuf;
   localparam int OVS = 16;

   logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
   logic cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_irq_done = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic txd, buf_empty, shift_done, tx_irq;

   int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 1, tcnt = 0, irq_cnt = 0;

   always #2.5 clk = ~clk;

   ser_tx_dbuf #(.DATA_W(8), .OVS(OVS)) u0 (.*);

   always @(negedge clk) begin
      cyc++;
      if (tx_irq) irq_cnt++;
      if (tcnt >= tdiv - 1) begin tcnt = 0; os_tick = 1'b1; end
      else begin tcnt++; os_tick = 1'b0; end
   end

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(negedge clk) if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
      report();
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic l8, input logic pe,
                                             input logic po, input logic s2, output int n);
      logic [11:0] f = '1;
      int nb = l8 ? 8 : 7;
      logic p = po;
      f[0] = 1'b0;
      for (int i = 0; i < nb; i++) begin f[i+1] = d[i]; p ^= d[i]; end
      if (pe) f[nb+1] = p;
      n = 1 + nb + (pe ? 1 : 0) + (s2 ? 2 : 1);
      return f;
   endfunction

   task automatic wait_ticks(input int n);
      int c = 0;
      while (c < n) begin @(posedge clk); if (os_tick) c++; end
      @(negedge clk);
   endtask

   task automatic pulse_wr(input logic [7:0] d);
      wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (!(txd && buf_empty && shift_done)) @(negedge clk);
   endtask

   // leaves the bench half a bit into the start bit
   task automatic find_start(input int t0);
      int lim = 40 * OVS * tdiv;
      int c0 = 0;
      while (txd !== 1'b0 && lim > 0) begin @(negedge clk); lim--; end
      chk(lim > 0, "R5 start bit seen", lim, 1);
      chk((cyc - t0) <= OVS * tdiv + 2, "R5 load within one bit", cyc - t0, OVS * tdiv + 2);
      chk(buf_empty === 1'b1, "R4 empty at start", buf_empty, 1);
      chk(shift_done === 1'b0, "R6 done cleared at start", shift_done, 0);
      @(posedge clk); if (os_tick) c0 = 1;
      @(negedge clk);
      chk(tx_irq === !cfg_irq_done, "R8 irq after empty rise", tx_irq, !cfg_irq_done);
      wait_ticks(OVS / 2 - c0);
   endtask

   task automatic check_bits(input logic [11:0] f, input int n, input bit last_done);
      for (int i = 0; i < n; i++) begin
         if (i > 0) wait_ticks(OVS);
         chk(txd === f[i], "R2 R3 R9 frame bit", txd, f[i]);
         chk(shift_done === (last_done && i == n - 1), "R6 shift_done level", shift_done,
             last_done && i == n - 1);
      end
   endtask

   task automatic send_one(input logic [7:0] d, input logic l8, input logic pe, input logic po,
                           input logic s2, input logic sel);
      int n, base, t0;
      logic [11:0] f;
      wait_idle();
      cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2; cfg_irq_done = sel;
      f = exp_frame(d, l8, pe, po, s2, n);
      base = irq_cnt; t0 = cyc;
      pulse_wr(d);
      chk(buf_empty === 1'b0, "R4 empty clears after write", buf_empty, 0);
      find_start(t0);
      check_bits(f, n, 1'b1);
      chk(irq_cnt - base == 1, "R8 one irq per char", irq_cnt - base, 1);
   endtask

   initial begin
      int n1, n2, base, t0, rep;
      logic [11:0] f1, f2;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk(txd === 1'b1 && buf_empty === 1'b1 && shift_done === 1'b1 && tx_irq === 1'b0,
          "R1 reset state", {txd, buf_empty, shift_done, tx_irq}, 4'b1110);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(txd === 1'b1 && tx_irq === 1'b0, "R1 idle after reset", {txd, tx_irq}, 2'b10);

      send_one(8'hA5, 1, 0, 0, 0, 0);        // R2 8N1
      send_one(8'h3C, 0, 1, 0, 1, 1);        // R3 R6 7E2, done irq
      send_one(8'h00, 1, 1, 1, 0, 0);        // R3 odd parity of zero
      send_one(8'hFF, 0, 1, 0, 0, 1);        // R3 bit 7 ignored in 7-bit mode
      tdiv = 3;
      send_one(8'h81, 1, 1, 0, 1, 1);        // R9 slower tick

      // R7 back-to-back
      wait_idle();
      tdiv = 2;
      cfg_len8 = 1; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop2 = 1; cfg_irq_done = 0;
      f1 = exp_frame(8'h5A, 1, 1, 0, 1, n1);
      f2 = exp_frame(8'hC3, 1, 1, 0, 1, n2);
      base = irq_cnt; t0 = cyc;
      pulse_wr(8'h5A);
      find_start(t0);
      fork pulse_wr(8'hC3); join_none
      check_bits(f1, n1, 1'b0);
      chk(buf_empty === 1'b0, "R7 second char held", buf_empty, 0);
      wait_ticks(OVS);
      chk(txd === 1'b0 && buf_empty === 1'b1, "R7 start follows stop", {txd, buf_empty}, 2'b01);
      check_bits(f2, n2, 1'b1);
      chk(irq_cnt - base == 2, "R7 R8 two irqs", irq_cnt - base, 2);

      for (int k = 0; k < 24; k++) begin
         wait_idle();
         tdiv = 1 + int'($urandom_range(0, 2));
         rep = $urandom;
         send_one(rep[7:0], rep[8], rep[9], rep[10], rep[11], rep[12]);
      end

      report();
      $finish;
   end
endmodule